// File: doc/BRIEF.md
# Eight-Phase Rotation Select Sequencer

This block drives the phase selector of a fractional clock divider. Eight copies of the input clock, spaced 45 degrees apart, are available. Each pulse on the `next_i` input moves the selection by one slot, which lengthens or shortens one output period of the divider by one eighth of an input period. A frame with a base modulus of 16 that sees M such pulses divides by 16 − M/8 when stepping backward and by 16 + M/8 when stepping forward. This spans 14.125 to 17.875.

A single down-counter of `next_i` rising edges serves both directions. A table maps the count onto a slot. In forward mode the table reads the bitwise complement of the count, so the same counter walks the slots the other way. The block registers both the slot index and an eight-bit one-hot select, so the downstream multiplexer sees a select that changes only once per step. Generating the phases and multiplexing the clock happen outside this block.

Top module: `phase_rotate_seq`

## Requirements
- R1: While `rst_i` is high on a rising clock edge, the block selects slot One: `phase_idx_o` = 0 and `phase_sel_o` = 8'b0000_0001. This holds whatever level `dir_fwd_i` has during reset, and the first pulse after reset steps away from slot One in the chosen direction.
- R2: A step is taken only at a rising edge of the clock where `next_i` is sampled high and was sampled low at the previous rising edge. Holding `next_i` high for many cycles takes exactly one step.
- R3: With `dir_fwd_i` = 0 (backward), each step moves the index to (index − 1) mod 8. From slot One the walk is One, Eight, Seven, Six, and so on, where slot k+1 is index k at k·45 degrees.
- R4: With `dir_fwd_i` = 1 (forward), each step moves the index to (index + 1) mod 8. From slot One the walk is Two, Three, and so on, and it wraps from Eight back to One.
- R5: A step detected at clock edge e becomes visible on `phase_idx_o` and `phase_sel_o` after edge e+1. Between steps both outputs hold their value, as long as `dir_fwd_i` is unchanged.
- R6: After reset, `phase_sel_o` has exactly one bit set, and that bit is at position `phase_idx_o`.
- R7: A backward frame of 15 steps starting at slot One ends at slot Two, which gives a ratio of 14.125. A forward frame of 7 steps starting at slot One ends at slot Eight, which gives 16.875.
- R8: The direction input only changes how the shared count is read. Flipping `dir_fwd_i` while at index s moves the selection one edge later to index (5 − s) mod 8, so slot One maps to slot Six and back again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every register updates on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| next_i | input | 1 | Step request; each rising edge advances one slot |
| dir_fwd_i | input | 1 | 1 = forward (index grows), 0 = backward (index shrinks) |
| phase_idx_o | output | 3 | Registered slot index, 0 = 0 degrees through 7 = 315 degrees |
| phase_sel_o | output | 8 | Registered one-hot select, bit k enables the phase at k·45 degrees |

## Verification
Some properties are checked by assertions on every cycle. These are the one-hot shape of the select and its agreement with the index, a single-cycle step for each rising edge of `next_i`, the count holding when there is no step, and a change of exactly ±1 slot per step in each direction. Other behaviour is shown only by the bench's scenarios. That covers the reset slot under both directions, the long walks with wrap-around, the 15-step and 7-step frames that set the 14.125 and 16.875 ratios, the one-cycle delay between a step and its appearance on the outputs, and the mirrored jump when the direction is flipped.

// File: rtl/phase_rotate_pkg.sv
package phase_rotate_pkg;

  // Meaning of the direction input inside the block
  typedef enum logic {
    STEP_BACK = 1'b0,
    STEP_FWD  = 1'b1
  } step_dir_e;

  // Default width of the phase index; slot count is 2**IDX_W
  localparam int unsigned DEF_IDX_W = 3;

endpackage

// File: rtl/rps_pulse_edge.sv
module rps_pulse_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,
  output logic step_o
);

  logic lvl_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) lvl_q <= 1'b1;  // a level already high at reset is not a step
    else       lvl_q <= lvl_i;
  end

  assign step_o = lvl_i & ~lvl_q;

  // R2: a held request yields a single step
  p_single_step_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    step_o |=> !step_o);

endmodule

// File: rtl/rps_step_counter.sv
module rps_step_counter
  import phase_rotate_pkg::*;
#(
  parameter int unsigned IDX_W = DEF_IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             step_i,
  input  logic             dir_fwd_i,
  output logic [IDX_W-1:0] cnt_o
);

  localparam int unsigned    N_SLOT   = 1 << IDX_W;
  localparam logic [IDX_W-1:0] ONE_W  = IDX_W'(1);
  // Count values that map to slot One in each reading of the table
  localparam logic [IDX_W-1:0] RST_BACK = IDX_W'(1);
  localparam logic [IDX_W-1:0] RST_FWD  = IDX_W'(N_SLOT - 2);

  step_dir_e        dir_w;
  logic [IDX_W-1:0] cnt_q;

  assign dir_w = step_dir_e'(dir_fwd_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= (dir_w == STEP_FWD) ? RST_FWD : RST_BACK;
    end else if (step_i) begin
      cnt_q <= cnt_q - ONE_W;
    end
  end

  assign cnt_o = cnt_q;

  // R2: no step, no count change
  p_hold_count_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(cnt_q));

endmodule

// File: rtl/rps_phase_map.sv
module rps_phase_map
  import phase_rotate_pkg::*;
#(
  parameter int unsigned IDX_W = DEF_IDX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [IDX_W-1:0]        cnt_i,
  input  logic                    dir_fwd_i,
  output logic [IDX_W-1:0]        idx_o,
  output logic [(1<<IDX_W)-1:0]   sel_o
);

  localparam int unsigned      N_SLOT   = 1 << IDX_W;
  localparam logic [IDX_W-1:0] ONE_W    = IDX_W'(1);
  localparam logic [IDX_W-1:0] FWD_BASE = IDX_W'(N_SLOT - 2);

  step_dir_e          dir_w;
  logic [IDX_W-1:0]   slot_w;
  logic [N_SLOT-1:0]  hit_w;
  logic [IDX_W-1:0]   idx_q;
  logic [N_SLOT-1:0]  sel_q;

  assign dir_w = step_dir_e'(dir_fwd_i);

  // Backward reads the count directly; forward reads its complement,
  // and (~c - 1) equals (N-2 - c) modulo N.
  always_comb begin
    if (dir_w == STEP_FWD) slot_w = FWD_BASE - cnt_i;
    else                   slot_w = cnt_i - ONE_W;
  end

  for (genvar k = 0; k < N_SLOT; k++) begin : g_decode
    assign hit_w[k] = (slot_w == IDX_W'(k));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      idx_q <= '0;
      sel_q <= N_SLOT'(1);
    end else begin
      idx_q <= slot_w;
      sel_q <= hit_w;
    end
  end

  assign idx_o = idx_q;
  assign sel_o = sel_q;

  // R6: exactly one phase enabled
  p_onehot_sel_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot(sel_q));

  // R6: enabled phase agrees with the index
  p_sel_matches_idx_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    sel_q[idx_q]);

  // R5: quiet inputs keep the select steady
  p_hold_idx_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    ($stable(cnt_i) && $stable(dir_fwd_i)) |=> ($stable(idx_q) && $stable(sel_q)));

endmodule

// File: rtl/phase_rotate_seq.sv
module phase_rotate_seq
  import phase_rotate_pkg::*;
#(
  parameter int unsigned IDX_W = DEF_IDX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  next_i,
  input  logic                  dir_fwd_i,
  output logic [IDX_W-1:0]      phase_idx_o,
  output logic [(1<<IDX_W)-1:0] phase_sel_o
);

  localparam int unsigned      N_SLOT = 1 << IDX_W;
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic             step_w;
  logic [IDX_W-1:0] cnt_w;

  rps_pulse_edge u_edge (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .lvl_i  (next_i),
    .step_o (step_w)
  );

  rps_step_counter #(.IDX_W(IDX_W)) u_count (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .step_i    (step_w),
    .dir_fwd_i (dir_fwd_i),
    .cnt_o     (cnt_w)
  );

  rps_phase_map #(.IDX_W(IDX_W)) u_map (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cnt_i     (cnt_w),
    .dir_fwd_i (dir_fwd_i),
    .idx_o     (phase_idx_o),
    .sel_o     (phase_sel_o)
  );

  // R3: a backward step lowers the index by one slot, two edges later
  p_back_step_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_w && !dir_fwd_i) ##1 !dir_fwd_i |=> (phase_idx_o == $past(phase_idx_o) - IDX_ONE));

  // R4: a forward step raises the index by one slot, two edges later
  p_fwd_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_w && dir_fwd_i) ##1 dir_fwd_i |=> (phase_idx_o == $past(phase_idx_o) + IDX_ONE));

endmodule

// File: tb/phase_rotate_seq_tb_top.sv
`timescale 1ns/1ps
module phase_rotate_seq_tb_top;

  localparam int unsigned IDX_W  = 3;
  localparam int unsigned N_SLOT = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              nxt = 1'b0;
  logic              dir = 1'b0;
  logic [IDX_W-1:0]  idx;
  logic [N_SLOT-1:0] sel;

  int checks = 0;
  int errors = 0;
  int exp_slot = 0;

  always #4 clk = ~clk;

  phase_rotate_seq #(.IDX_W(IDX_W)) dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .next_i      (nxt),
    .dir_fwd_i   (dir),
    .phase_idx_o (idx),
    .phase_sel_o (sel)
  );

  task automatic expect_slot(input string tag, input int slot);
    logic [N_SLOT-1:0] want_sel;
    want_sel = N_SLOT'(1) << slot;
    checks++;
    if (idx !== IDX_W'(slot)) begin
      errors++;
      $display("FAIL %s index: actual %0d expected %0d", tag, idx, slot);
    end
    checks++;
    if (sel !== want_sel) begin
      errors++;
      $display("FAIL %s R6 select: actual %b expected %b", tag, sel, want_sel);
    end
  endtask

  // Apply reset with a given direction, release, and check slot One
  task automatic do_reset(input logic fwd);
    @(negedge clk);
    rst = 1'b1; nxt = 1'b0; dir = fwd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_slot = 0;
    expect_slot("R1 reset", 0);
  endtask

  // One step: outputs must still show the old slot one cycle after the
  // detecting edge (R5), and the new slot one cycle later.
  task automatic pulse(input string tag);
    @(negedge clk);
    nxt = 1'b1;
    @(negedge clk);
    expect_slot({tag, " R5 not yet"}, exp_slot);
    nxt = 1'b0;
    exp_slot = dir ? (exp_slot + 1) % N_SLOT : (exp_slot + N_SLOT - 1) % N_SLOT;
    @(negedge clk);
    expect_slot(tag, exp_slot);
  endtask

  task automatic t_reset_both;
    do_reset(1'b0);
    do_reset(1'b1);
    repeat (4) @(negedge clk);
    expect_slot("R1 idle after reset", 0);
  endtask

  task automatic t_backward_walk;
    do_reset(1'b0);
    for (int i = 0; i < 10; i++) pulse("R3 backward");
  endtask

  task automatic t_forward_walk;
    do_reset(1'b1);
    for (int i = 0; i < 10; i++) pulse("R4 forward");
  endtask

  task automatic t_held_next;
    do_reset(1'b1);
    @(negedge clk);
    nxt = 1'b1;
    repeat (6) @(negedge clk);
    expect_slot("R2 held high", 1);
    nxt = 1'b0;
    repeat (3) @(negedge clk);
    expect_slot("R2 after release", 1);
    exp_slot = 1;
    pulse("R2 next edge");
  endtask

  task automatic t_frames;
    do_reset(1'b0);
    for (int i = 0; i < 15; i++) pulse("R7 back frame");
    expect_slot("R7 ratio 14.125 end slot", 1);
    do_reset(1'b1);
    for (int i = 0; i < 7; i++) pulse("R7 fwd frame");
    expect_slot("R7 ratio 16.875 end slot", 7);
  endtask

  task automatic t_dir_flip;
    do_reset(1'b0);
    @(negedge clk);
    dir = 1'b1;
    @(negedge clk);
    exp_slot = 5;
    expect_slot("R8 flip to forward", 5);
    pulse("R8 forward after flip");
    @(negedge clk);
    dir = 1'b0;
    @(negedge clk);
    exp_slot = (5 - exp_slot + N_SLOT) % N_SLOT;
    expect_slot("R8 flip to backward", exp_slot);
    pulse("R8 backward after flip");
  endtask

  initial begin
    t_reset_both();
    t_backward_walk();
    t_forward_walk();
    t_held_next();
    t_frames();
    t_dir_flip();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule